// File: doc/BRIEF.md
# Frame Processing Sequencer

This block runs one pass of an image pre-processing pipeline each time a host asks for it. A host sets a request flag through a 32-bit register port. The sequencer then opens the raw frame buffer to the camera for exactly one frame, delimited by start-of-frame and end-of-frame markers. It starts the colour threshold stage, and after that the noise filter stage. While a stage runs, the sequencer gives that stage sole ownership of the shared binary mask memory. Last, it launches a DMA copy of the mask into host memory.

When the copy finishes, the sequencer raises a completion flag and emits a one-cycle "mask ready" pulse for the downstream segmentation software. It holds the completion flag until the host withdraws its request, and only then goes idle. The threshold stage, the filter stage and the DMA engine are outside this block. The sequencer talks to each of them through a start pulse and a done strobe. It also produces the write enable and the pixel address for the raw frame buffer. By default that buffer is sized for 640x480 pixels of 10 bits.

Top module: `frame_seq_top`

## Requirements
- R1: While the synchronous active-low reset is applied, and on the first cycle after release, the status word reads zero. No grant, start pulse, frame-ready pulse or frame buffer write enable is active, whatever the inputs are.
- R2: A write with `host_wdata[0]`=1 sets the request flag. The status word reports the request in bit 0, busy in bit 1 and done in bit 2, and its other bits read zero. Busy rises one cycle after the request flag reads 1.
- R3: Once busy, the sequencer waits for `cam_sof`. Frame buffer writes are enabled only between that cycle and `cam_eof`, inclusive of the `cam_eof` cycle and exclusive of the `cam_sof` cycle. In that window `fb_wr_en` follows `cam_pix_valid` combinationally.
- R4: The frame buffer address is 0 for the first accepted pixel and advances by one for each accepted pixel. After FRAME_PIXELS accepted pixels, no further write is enabled for the rest of the frame.
- R5: The cycle after `cam_eof`, `thr_start` pulses for one cycle, and `mask_grant` reads 01 (bit 0 = threshold stage) until the cycle after `thr_done`.
- R6: The cycle after `thr_done`, `flt_start` pulses for one cycle, and `mask_grant` reads 10 (bit 1 = filter stage) until the cycle after `flt_done`.
- R7: At most one `mask_grant` bit is set in any cycle. No grant is given during capture, DMA, done or idle.
- R8: The cycle after `flt_done`, `dma_start` pulses for one cycle. The sequencer then waits for `dma_done`. A done strobe from a stage that is not currently active has no effect.
- R9: The cycle after `dma_done`, busy clears, done sets and `frame_ready` pulses for one cycle. Done stays set while the request flag is 1. Once the host clears the request, done clears one cycle later and the sequencer is idle.
- R10: A write that sets the request while the sequencer is not idle is dropped. A write that clears the request is always taken. A request cleared during a run therefore causes no second frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe for the control word |
| host_wdata | input | 32 | Control word; bit 0 is the request flag |
| host_rdata | output | 32 | Status word: bit 0 request, bit 1 busy, bit 2 done |
| cam_sof | input | 1 | Camera start-of-frame marker |
| cam_eof | input | 1 | Camera end-of-frame marker |
| cam_pix_valid | input | 1 | Camera pixel present this cycle |
| fb_wr_en | output | 1 | Raw frame buffer write enable |
| fb_wr_addr | output | ADDR_W | Raw frame buffer pixel address |
| mask_grant | output | 2 | One-hot mask memory owner (bit 0 threshold, bit 1 filter) |
| thr_start | output | 1 | Threshold stage start pulse |
| thr_done | input | 1 | Threshold stage done strobe |
| flt_start | output | 1 | Filter stage start pulse |
| flt_done | input | 1 | Filter stage done strobe |
| dma_start | output | 1 | DMA transfer start pulse |
| dma_done | input | 1 | DMA transfer done strobe |
| frame_ready | output | 1 | One-cycle pulse when the mask is in host memory |

## Verification
Each state-changing input (request write, marker, done strobe) takes effect at the next clock edge. Status, grant, start and ready outputs therefore change one cycle after the stimulus. Busy trails a request write by two cycles, because the request flag register sits in front of the state register. `fb_wr_en` and `fb_wr_addr` are the exception: the enable is combinational on `cam_pix_valid`, and the address advances one cycle after each accepted pixel. The bench applies each vector on the falling edge, compares all outputs just after that, and lets exactly one rising edge pass before the next vector. Expected values therefore always describe the state left by the previous edges.

// File: rtl/frame_seq_pkg.sv
// Shared types and field positions for the frame sequencer.
// Assumes a single 32-bit control/status word on the host side.
package frame_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_SOF = 3'd1,
        ST_CAPTURE  = 3'd2,
        ST_THRESH   = 3'd3,
        ST_FILTER   = 3'd4,
        ST_DMA      = 3'd5,
        ST_DONE     = 3'd6
    } seq_state_e;

    localparam int REG_W      = 32;
    localparam int CTL_REQ    = 0;
    localparam int STS_REQ    = 0;
    localparam int STS_BUSY   = 1;
    localparam int STS_DONE   = 2;

    localparam int GRANT_N    = 2;
    localparam int GNT_THRESH = 0;
    localparam int GNT_FILTER = 1;

    // State that owns a given mask memory grant line.
    function automatic seq_state_e grant_owner(input int idx);
        return (idx == GNT_THRESH) ? ST_THRESH : ST_FILTER;
    endfunction

endpackage

// File: rtl/frame_seq_host_if.sv
// Host register port: keeps the request flag and assembles the status word.
// Assumes one write-only control field and a read-only status view.
// A set of the request is taken only while idle; a clear is always taken.
module frame_seq_host_if
    import frame_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_req_bit,
    input  logic             idle,
    input  logic             busy,
    input  logic             done,
    output logic             req,
    output logic [REG_W-1:0] rdata
);

    // Request flag: set only from idle, cleared at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else if (wr_en) begin
            if (wr_req_bit) begin
                if (idle) begin
                    req <= 1'b1;
                end
            end else begin
                req <= 1'b0;
            end
        end
    end

    // Status word assembly, unused bits held at zero.
    always_comb begin
        rdata           = '0;
        rdata[STS_REQ]  = req;
        rdata[STS_BUSY] = busy;
        rdata[STS_DONE] = done;
    end

endmodule

// File: rtl/frame_seq_fsm.sv
// Sequencing state machine: capture, threshold, filter, transfer, done.
// Assumes done strobes and frame markers are synchronous single-cycle pulses.
// Start and ready pulses are registered on entry to their state.
module frame_seq_fsm
    import frame_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       sof,
    input  logic       eof,
    input  logic       thr_done,
    input  logic       flt_done,
    input  logic       dma_done,
    output seq_state_e state,
    output logic       cap_begin,
    output logic       cap_open,
    output logic       thr_start,
    output logic       flt_start,
    output logic       dma_start,
    output logic       ready_pulse
);

    seq_state_e state_d;

    // Next-state selection; strobes outside their state are ignored.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:     if (req)      state_d = ST_WAIT_SOF;
            ST_WAIT_SOF: if (sof)      state_d = ST_CAPTURE;
            ST_CAPTURE:  if (eof)      state_d = ST_THRESH;
            ST_THRESH:   if (thr_done) state_d = ST_FILTER;
            ST_FILTER:   if (flt_done) state_d = ST_DMA;
            ST_DMA:      if (dma_done) state_d = ST_DONE;
            ST_DONE:     if (!req)     state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Entry pulses for the stage starts and the completion marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_start   <= 1'b0;
            flt_start   <= 1'b0;
            dma_start   <= 1'b0;
            ready_pulse <= 1'b0;
        end else begin
            thr_start   <= (state_d == ST_THRESH) && (state != ST_THRESH);
            flt_start   <= (state_d == ST_FILTER) && (state != ST_FILTER);
            dma_start   <= (state_d == ST_DMA)    && (state != ST_DMA);
            ready_pulse <= (state_d == ST_DONE)   && (state != ST_DONE);
        end
    end

    // Capture window flags for the frame buffer address logic.
    always_comb begin
        cap_begin = (state == ST_WAIT_SOF) && sof;
        cap_open  = (state == ST_CAPTURE);
    end

endmodule

// File: rtl/frame_seq_fb_addr.sv
// Frame buffer write control: pixel counter with a hard stop at frame size.
// Assumes the counter is cleared when capture opens and is only advanced
// by accepted pixels; excess pixels of an oversize frame are dropped.
module frame_seq_fb_addr #(
    parameter int FRAME_PIXELS = 307200,
    localparam int CNT_W  = $clog2(FRAME_PIXELS + 1),
    localparam int ADDR_W = $clog2(FRAME_PIXELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              open,
    input  logic              pix_valid,
    output logic              wr_en,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FRAME_PIXELS);

    logic [CNT_W-1:0] count;
    logic             full;

    // Write gate: open window, pixel present, frame not yet full.
    always_comb begin
        full  = (count == LIMIT);
        wr_en = open && pix_valid && !full;
        addr  = count[ADDR_W-1:0];
    end

    // Pixel counter, cleared at start of capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (wr_en) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/frame_seq_mask_arb.sv
// Mask memory ownership decode: one grant line per stage, from the state.
// Assumes each grant line belongs to exactly one distinct state.
module frame_seq_mask_arb
    import frame_seq_pkg::*;
(
    input  seq_state_e         state,
    output logic [GRANT_N-1:0] grant
);

    // One grant line per stage.
    for (genvar g = 0; g < GRANT_N; g++) begin : g_grant
        assign grant[g] = (state == grant_owner(g));
    end

endmodule

// File: rtl/frame_seq_top.sv
// Top of the frame sequencer: host handshake, capture window, stage
// sequencing and mask memory ownership.
// Assumes all inputs are synchronous to clk; synchronous active-low reset.
module frame_seq_top
    import frame_seq_pkg::*;
#(
    parameter int FRAME_PIXELS = 307200,
    localparam int ADDR_W = $clog2(FRAME_PIXELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              cam_sof,
    input  logic              cam_eof,
    input  logic              cam_pix_valid,
    output logic              fb_wr_en,
    output logic [ADDR_W-1:0] fb_wr_addr,
    output logic [1:0]        mask_grant,
    output logic              thr_start,
    input  logic              thr_done,
    output logic              flt_start,
    input  logic              flt_done,
    output logic              dma_start,
    input  logic              dma_done,
    output logic              frame_ready
);

    seq_state_e state;
    logic       req;
    logic       idle;
    logic       busy;
    logic       done;
    logic       cap_begin;
    logic       cap_open;
    logic       unused_wdata;

    // Status decode from the state.
    always_comb begin
        idle         = (state == ST_IDLE);
        done         = (state == ST_DONE);
        busy         = !idle && !done;
        unused_wdata = ^host_wdata[REG_W-1:1];
    end

    frame_seq_host_if u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (host_wr_en),
        .wr_req_bit (host_wdata[CTL_REQ]),
        .idle       (idle),
        .busy       (busy),
        .done       (done),
        .req        (req),
        .rdata      (host_rdata)
    );

    frame_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .sof         (cam_sof),
        .eof         (cam_eof),
        .thr_done    (thr_done),
        .flt_done    (flt_done),
        .dma_done    (dma_done),
        .state       (state),
        .cap_begin   (cap_begin),
        .cap_open    (cap_open),
        .thr_start   (thr_start),
        .flt_start   (flt_start),
        .dma_start   (dma_start),
        .ready_pulse (frame_ready)
    );

    frame_seq_fb_addr #(
        .FRAME_PIXELS (FRAME_PIXELS)
    ) u_fb (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cap_begin),
        .open      (cap_open),
        .pix_valid (cam_pix_valid),
        .wr_en     (fb_wr_en),
        .addr      (fb_wr_addr)
    );

    frame_seq_mask_arb u_arb (
        .state (state),
        .grant (mask_grant)
    );

endmodule

// File: rtl/frame_seq_chk.sv
// Protocol checker for the frame sequencer, attached by bind.
// Observes only the top-level ports.
module frame_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] sts,
    input logic [1:0] grant,
    input logic       fb_wr_en,
    input logic       thr_start,
    input logic       flt_start,
    input logic       dma_start,
    input logic       frame_ready
);

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R7
    AST_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) fb_wr_en |-> sts[1]); // R3
    AST_THR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) thr_start |=> !thr_start); // R5
    AST_THR_GRANT: assert property (@(posedge clk) disable iff (!rst_n) thr_start |-> grant[0]); // R5
    AST_FLT_GRANT: assert property (@(posedge clk) disable iff (!rst_n) flt_start |-> grant[1]); // R6
    AST_DMA_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n) dma_start |-> (grant == 2'b00)); // R8
    AST_READY_DONE: assert property (@(posedge clk) disable iff (!rst_n) frame_ready |-> (sts[2] && !sts[1])); // R9
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (sts[2] && sts[0]) |=> sts[2]); // R9
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(sts[1] && sts[2])); // R2

endmodule

bind frame_seq_top frame_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sts         (host_rdata[2:0]),
    .grant       (mask_grant),
    .fb_wr_en    (fb_wr_en),
    .thr_start   (thr_start),
    .flt_start   (flt_start),
    .dma_start   (dma_start),
    .frame_ready (frame_ready)
);

// File: tb/frame_seq_top_tb_top.sv
`timescale 1ns/100ps
module frame_seq_top_tb_top;

    localparam int NPIX   = 4;
    localparam int AW     = $clog2(NPIX);
    localparam int NSTEPS = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr_en = 1'b0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic          cam_sof = 1'b0, cam_eof = 1'b0, cam_pix_valid = 1'b0;
    logic          fb_wr_en;
    logic [AW-1:0] fb_wr_addr;
    logic [1:0]    mask_grant;
    logic          thr_start, flt_start, dma_start, frame_ready;
    logic          thr_done = 1'b0, flt_done = 1'b0, dma_done = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    frame_seq_top #(.FRAME_PIXELS(NPIX)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cam_sof(cam_sof), .cam_eof(cam_eof), .cam_pix_valid(cam_pix_valid),
        .fb_wr_en(fb_wr_en), .fb_wr_addr(fb_wr_addr), .mask_grant(mask_grant),
        .thr_start(thr_start), .thr_done(thr_done),
        .flt_start(flt_start), .flt_done(flt_done),
        .dma_start(dma_start), .dma_done(dma_done),
        .frame_ready(frame_ready)
    );

    // Row: stimulus {wr, wd0, sof, eof, pix, thr_d, flt_d, dma_d},
    //      expect   {busy, done, g1, g0, thr_s, flt_s, dma_s, ready, wr_en},
    //      expected address (FF = not checked).
    localparam logic [24:0] TBL [NSTEPS] = '{
        {8'b00000000, 9'b000000000, 8'hFF},  // R1 idle after reset
        {8'b11000000, 9'b000000000, 8'hFF},  // R2 write request
        {8'b00000000, 9'b000000000, 8'hFF},  // R2 flag set, not yet busy
        {8'b00101000, 9'b100000000, 8'hFF},  // R3 busy, pixel before sof dropped
        {8'b00001000, 9'b100000001, 8'h00},  // R4 first pixel at 0
        {8'b00001000, 9'b100000001, 8'h01},  // R4
        {8'b00000000, 9'b100000000, 8'h02},  // R3 no pixel, no write
        {8'b00001000, 9'b100000001, 8'h02},  // R4
        {8'b00001000, 9'b100000001, 8'h03},  // R4 last pixel
        {8'b00011000, 9'b100000000, 8'hFF},  // R4 full frame, extra pixel dropped
        {8'b00000010, 9'b100110000, 8'hFF},  // R5 threshold start, stray filter done
        {8'b00000100, 9'b100100000, 8'hFF},  // R5 grant held
        {8'b00000010, 9'b101001000, 8'hFF},  // R6 filter start and grant
        {8'b00000100, 9'b100000100, 8'hFF},  // R7 no grant in DMA, stray thr done
        {8'b00000001, 9'b100000000, 8'hFF},  // R8 waiting for transfer
        {8'b00000000, 9'b010000010, 8'hFF},  // R9 done and ready pulse
        {8'b10000000, 9'b010000000, 8'hFF},  // R9 host clears request
        {8'b00000000, 9'b010000000, 8'hFF},  // R9 done held one more cycle
        {8'b00000000, 9'b000000000, 8'hFF}   // R9 back to idle
    };

    string row_tag [NSTEPS] = '{"R1", "R2", "R2", "R3", "R4", "R4", "R3", "R4", "R4", "R4",
                                "R5", "R5", "R6", "R7", "R8", "R9", "R9", "R9", "R9"};

    task automatic check(input string tag, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic host_write(input logic bit0);
        host_wr_en = 1'b1;
        host_wdata = {31'd0, bit0};
        tick();
        host_wr_en = 1'b0;
        host_wdata = '0;
    endtask

    function automatic logic [8:0] observed();
        return {host_rdata[1], host_rdata[2], mask_grant, thr_start, flt_start,
                dma_start, frame_ready, fb_wr_en};
    endfunction

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet under reset even with inputs active.
        cam_pix_valid = 1'b1;
        repeat (3) tick();
        check("R1", "status in reset", host_rdata, 32'h0);
        check("R1", "outputs in reset", {23'd0, observed()}, 32'h0);
        cam_pix_valid = 1'b0;
        rst_n = 1'b1;

        // Vector table walk.
        for (int i = 0; i < NSTEPS; i++) begin
            {host_wr_en, host_wdata[0], cam_sof, cam_eof, cam_pix_valid,
             thr_done, flt_done, dma_done} = TBL[i][24:17];
            #0.5;
            check(row_tag[i], $sformatf("step %0d outputs", i),
                  {23'd0, observed()}, {23'd0, TBL[i][16:8]});
            if (TBL[i][7:0] != 8'hFF)
                check(row_tag[i], $sformatf("step %0d address", i),
                      {30'd0, fb_wr_addr}, {24'd0, TBL[i][7:0]});
            tick();
        end
        {host_wr_en, host_wdata, cam_sof, cam_eof, cam_pix_valid,
         thr_done, flt_done, dma_done} = '0;
        check("R2", "status reserved bits idle", host_rdata, 32'h0);

        // R10: request cleared mid-run, re-set while busy is dropped.
        host_write(1'b1);
        tick();
        check("R2", "busy after request", host_rdata, 32'h3);
        host_write(1'b0);
        host_write(1'b1);
        check("R10", "set while busy dropped", host_rdata, 32'h2);
        cam_sof = 1'b1; tick(); cam_sof = 1'b0;
        cam_eof = 1'b1; tick(); cam_eof = 1'b0;
        thr_done = 1'b1; tick(); thr_done = 1'b0;
        flt_done = 1'b1; tick(); flt_done = 1'b0;
        dma_done = 1'b1; tick(); dma_done = 1'b0;
        check("R9", "done without request", host_rdata, 32'h4);
        tick();
        check("R10", "idle after run", host_rdata, 32'h0);
        repeat (4) tick();
        check("R10", "no second frame", host_rdata, 32'h0);

        // R1: reset in the middle of a capture.
        host_write(1'b1);
        tick();
        cam_sof = 1'b1; tick(); cam_sof = 1'b0;
        cam_pix_valid = 1'b1;
        #0.5;
        check("R3", "capture write enabled", {31'd0, fb_wr_en}, 32'h1);
        rst_n = 1'b0;
        tick();
        check("R1", "status after mid-run reset", host_rdata, 32'h0);
        check("R1", "outputs after mid-run reset", {23'd0, observed()}, 32'h0);
        cam_pix_valid = 1'b0;
        rst_n = 1'b1;
        tick();
        check("R1", "idle after release", host_rdata, 32'h0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule